// File: doc/BRIEF.md
# Skewed-Bank Fully Associative Branch Target Buffer

This block is a small first-level branch target buffer. It holds 64 entries in four equal banks of 16. Every lookup goes to one bank only. The bank number is a cheap hash of a few instruction-address bits, so a lookup does 16 tag compares instead of 64. The other three banks stay idle for that cycle. On a hit the block returns the stored branch target and a 2-bit branch kind. The bank-enable vector of each lookup is also brought out, so the bank steering can be seen from outside.

The hash is two address bits combined by XOR with the next two bits above them. Because of this skew, branches that share their low index bits still spread over all four banks. The same hash steers both allocations and lookups. A fetch unit presents a PC on the lookup port and gets the result one clock later.

The execution side writes through the update port. If the PC is already held, the update rewrites the target and kind of that entry in place. Otherwise it allocates a new entry in the hashed bank: a free entry first, and when the bank is full a per-bank rotating victim. No entry carries any field beyond tag, target, kind and valid.

Top module: `skew_bank_btb`

## Requirements
- R1: The buffer holds 64 entries as 4 banks of 16. Sixteen distinct PCs that hash to one bank can all be resident at once and all hit.
- R2: A lookup request enables exactly one bank. `lk_bank_en` is one-hot with bit b set for bank b. When no lookup is requested, `lk_bank_en` is zero and `lk_hit` is 0.
- R3: The bank number is the 2-bit value PC[4:3] XOR PC[6:5]. This value is used for both update and lookup.
- R4: Lookup results are registered. Values presented on a clock edge appear on the outputs just after that edge and no earlier.
- R5: A hit returns the target and kind that were last written for that PC.
- R6: A miss gives `lk_hit`=0, `lk_target`=0 and `lk_type`=0.
- R7: The tag is PC[31:5]. PC bits [2:0] do not affect a lookup. Two PCs with equal bits [31:5] but different bits [4:3] fall in different banks and are separate entries.
- R8: An allocation takes the lowest-numbered free entry of its bank. An entry stays valid until reset.
- R9: An update to a resident PC rewrites its target and kind in place and allocates nothing. Re-updating one PC never evicts another.
- R10: In a full bank, allocations replace entries in rotating order starting from entry 0. Other banks are untouched.
- R11: Reset leaves every entry invalid, and every lookup misses.
- R12: A lookup in the same cycle as an update sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_pc | input | 32 | Lookup PC |
| lk_hit | output | 1 | Registered hit |
| lk_target | output | 32 | Registered target on hit, zero on miss |
| lk_type | output | 2 | Registered branch kind on hit, zero on miss |
| lk_bank_en | output | 4 | Registered one-hot bank enable of the lookup |
| up_valid | input | 1 | Update request |
| up_pc | input | 32 | Branch PC to install or refresh |
| up_target | input | 32 | Target to store |
| up_type | input | 2 | Branch kind to store |

## Verification
The bench fills one bank to capacity, then allocates past it. Two things follow. A victim pointer that does not start at entry 0, or does not rotate, evicts the wrong branch. A fill that does not take free entries in order makes the eviction order wrong too. The bench rewrites one resident PC over and over while the bank is full; a design that allocates duplicates would push other branches out, and they would then miss. The bench flips PC bits [4:3] and [6:5] and low bits [2:0], which catches a hash that uses the wrong bits or a tag that includes or leaves out the wrong bits. A lookup issued in the same cycle as an update to the same PC must miss; a design that forwards the write, or adds a cycle of latency, gives a different result.

// File: rtl/btbk_pkg.sv
package btbk_pkg;
    // lowest PC bits below the instruction grain, ignored everywhere
    localparam int unsigned PC_GRAIN_BITS = 3;

    typedef enum logic [1:0] {
        BRK_COND = 2'd0,
        BRK_JUMP = 2'd1,
        BRK_CALL = 2'd2,
        BRK_RET  = 2'd3
    } br_kind_e;

    localparam int unsigned KIND_W = $bits(br_kind_e);
endpackage

// File: rtl/btbk_bank_sel.sv
module btbk_bank_sel #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned IDX_LSB = 3
) (
    input  logic [PC_W-1:0]       pc,
    input  logic                  req,
    output logic [SEL_W-1:0]      bank_idx,
    output logic [(1<<SEL_W)-1:0] bank_en
);
    localparam int unsigned NB = 1 << SEL_W;

    // skew: index bits folded with the bits directly above them
    assign bank_idx = pc[IDX_LSB +: SEL_W] ^ pc[IDX_LSB + SEL_W +: SEL_W];

    for (genvar b = 0; b < NB; b++) begin : g_dec
        assign bank_en[b] = req && (bank_idx == SEL_W'(b));
    end

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:IDX_LSB+2*SEL_W], pc[IDX_LSB-1:0]};
endmodule

// File: rtl/btbk_bank.sv
module btbk_bank #(
    parameter int unsigned TAG_W  = 27,
    parameter int unsigned TGT_W  = 32,
    parameter int unsigned KIND_W = 2,
    parameter int unsigned DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [TGT_W-1:0]  rd_target,
    output logic [KIND_W-1:0] rd_kind,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [TGT_W-1:0]  wr_target,
    input  logic [KIND_W-1:0] wr_kind
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q [DEPTH];
    logic [TGT_W-1:0]  tgt_q [DEPTH];
    logic [KIND_W-1:0] knd_q [DEPTH];
    logic [IDX_W-1:0]  rr_q;

    logic [DEPTH-1:0] rd_match;
    logic [DEPTH-1:0] wr_match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign rd_match[i] = rd_en && vld_q[i] && (tag_q[i] == rd_tag);
        assign wr_match[i] = vld_q[i] && (tag_q[i] == wr_tag);
    end

    // read side: and-or mux over the (at most one) matching entry
    always_comb begin
        rd_target = '0;
        rd_kind   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            rd_target = rd_target | ({TGT_W{rd_match[i]}} & tgt_q[i]);
            rd_kind   = rd_kind   | ({KIND_W{rd_match[i]}} & knd_q[i]);
        end
    end
    assign rd_hit = |rd_match;

    // write side: in-place refresh, else lowest free entry, else rotating victim
    logic             free_any;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] match_idx;
    always_comb begin
        free_any  = 1'b0;
        free_idx  = '0;
        match_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (wr_match[i]) begin
                match_idx = IDX_W'(i);
            end
        end
    end

    logic             wr_refresh;
    logic [IDX_W-1:0] wr_idx;
    assign wr_refresh = |wr_match;
    assign wr_idx     = wr_refresh ? match_idx : (free_any ? free_idx : rr_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            rr_q  <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            if (!wr_refresh && !free_any) begin
                rr_q <= (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
            knd_q[wr_idx] <= wr_kind;
        end
    end

    AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_match)) else $error("duplicate tag in bank"); // R9
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((vld_q & $past(vld_q)) == $past(vld_q))) else $error("entry lost valid"); // R8
endmodule

// File: rtl/skew_bank_btb.sv
module skew_bank_btb #(
    parameter int unsigned PC_W       = 32,
    parameter int unsigned TGT_W      = 32,
    parameter int unsigned NUM_BANKS  = 4,
    parameter int unsigned BANK_DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           lk_req,
    input  logic [PC_W-1:0]                lk_pc,
    output logic                           lk_hit,
    output logic [TGT_W-1:0]               lk_target,
    output logic [btbk_pkg::KIND_W-1:0]    lk_type,
    output logic [NUM_BANKS-1:0]           lk_bank_en,
    input  logic                           up_valid,
    input  logic [PC_W-1:0]                up_pc,
    input  logic [TGT_W-1:0]               up_target,
    input  logic [btbk_pkg::KIND_W-1:0]    up_type
);
    import btbk_pkg::*;

    localparam int unsigned SEL_W   = $clog2(NUM_BANKS);
    localparam int unsigned IDX_LSB = PC_GRAIN_BITS;
    localparam int unsigned TAG_LSB = IDX_LSB + SEL_W;
    localparam int unsigned TAG_W   = PC_W - TAG_LSB;

    logic [SEL_W-1:0]     lk_sel, up_sel;
    logic [NUM_BANKS-1:0] lk_en_c, up_en_c;

    btbk_bank_sel #(.PC_W(PC_W), .SEL_W(SEL_W), .IDX_LSB(IDX_LSB)) u_lk_sel (
        .pc(lk_pc), .req(lk_req), .bank_idx(lk_sel), .bank_en(lk_en_c)
    );
    btbk_bank_sel #(.PC_W(PC_W), .SEL_W(SEL_W), .IDX_LSB(IDX_LSB)) u_up_sel (
        .pc(up_pc), .req(up_valid), .bank_idx(up_sel), .bank_en(up_en_c)
    );

    logic unused_sel;
    assign unused_sel = ^{lk_sel, up_sel};

    logic [TAG_W-1:0] lk_tag, up_tag;
    assign lk_tag = lk_pc[PC_W-1:TAG_LSB];
    assign up_tag = up_pc[PC_W-1:TAG_LSB];

    logic [NUM_BANKS-1:0] b_hit;
    logic [TGT_W-1:0]     b_tgt [NUM_BANKS];
    logic [KIND_W-1:0]    b_knd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        btbk_bank #(
            .TAG_W(TAG_W), .TGT_W(TGT_W), .KIND_W(KIND_W), .DEPTH(BANK_DEPTH)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .rd_en(lk_en_c[b]), .rd_tag(lk_tag),
            .rd_hit(b_hit[b]), .rd_target(b_tgt[b]), .rd_kind(b_knd[b]),
            .wr_en(up_en_c[b]), .wr_tag(up_tag),
            .wr_target(up_target), .wr_kind(up_type)
        );
    end

    logic [TGT_W-1:0]  hit_tgt_c;
    logic [KIND_W-1:0] hit_knd_c;
    always_comb begin
        hit_tgt_c = '0;
        hit_knd_c = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            hit_tgt_c = hit_tgt_c | b_tgt[b];
            hit_knd_c = hit_knd_c | b_knd[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_hit     <= 1'b0;
            lk_target  <= '0;
            lk_type    <= '0;
            lk_bank_en <= '0;
        end else begin
            lk_hit     <= |b_hit;
            lk_target  <= hit_tgt_c;
            lk_type    <= hit_knd_c;
            lk_bank_en <= lk_en_c;
        end
    end

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> $onehot(lk_bank_en)) else $error("bank enable not one-hot"); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (lk_bank_en == '0 && !lk_hit)) else $error("idle lookup active"); // R2
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_target == '0 && lk_type == '0)) else $error("miss data nonzero"); // R6
    AST_HIT_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_bank_en != '0)) else $error("hit without bank"); // R2
endmodule

// File: tb/sim_skew_bank_btb.sv
module sim_skew_bank_btb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit;
    logic [31:0] lk_target;
    logic [1:0]  lk_type;
    logic [3:0]  lk_bank_en;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic [31:0] up_target = '0;
    logic [1:0]  up_type = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    skew_bank_btb u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_pc(lk_pc),
        .lk_hit(lk_hit), .lk_target(lk_target), .lk_type(lk_type), .lk_bank_en(lk_bank_en),
        .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target), .up_type(up_type)
    );

    function automatic logic [31:0] mkpc(int b, int k, int s);
        return (32'(k) << 7) | (32'(s & 3) << 5) | (32'((b ^ s) & 3) << 3);
    endfunction
    function automatic logic [31:0] tgt_of(logic [31:0] pc);
        return pc ^ 32'h5A3C_0000;
    endfunction
    function automatic logic [3:0] exp_en(logic [31:0] pc);
        return 4'b0001 << (pc[4:3] ^ pc[6:5]);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_update(input logic [31:0] pc, input logic [31:0] tgt, input logic [1:0] ty);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_target = tgt; up_type = ty;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [31:0] pc, output logic h, output logic [31:0] t,
                             output logic [1:0] ty, output logic [3:0] en);
        @(negedge clk);
        lk_req = 1'b1; lk_pc = pc;
        @(negedge clk);
        h = lk_hit; t = lk_target; ty = lk_type; en = lk_bank_en;
        lk_req = 1'b0;
    endtask

    task automatic expect_hit(input logic [31:0] pc, input logic [31:0] tgt,
                              input logic [1:0] ty, input string req);
        logic h; logic [31:0] t; logic [1:0] y; logic [3:0] e;
        do_lookup(pc, h, t, y, e);
        chk(h === 1'b1, req, "hit", 64'(h), 64'd1);
        chk(t === tgt, req, "target", 64'(t), 64'(tgt));
        chk(y === ty, req, "type", 64'(y), 64'(ty));
    endtask

    task automatic expect_miss(input logic [31:0] pc, input string req);
        logic h; logic [31:0] t; logic [1:0] y; logic [3:0] e;
        do_lookup(pc, h, t, y, e);
        chk(h === 1'b0, req, "miss", 64'(h), 64'd0);
        chk(t === 32'd0 && y === 2'd0, req, "miss data zero", 64'({t, y}), 64'd0);
    endtask

    // R11 R2: after reset everything misses, outputs idle
    task automatic t_reset;
        chk(lk_hit === 1'b0 && lk_bank_en === 4'd0, "R11", "reset outputs",
            64'({lk_hit, lk_bank_en}), 64'd0);
        for (int i = 0; i < 4; i++) expect_miss(mkpc(i, i + 1, i), "R11");
    endtask

    // R3 R2: hashed bank selection, idle gives zero enable
    task automatic t_hash;
        logic h; logic [31:0] t; logic [1:0] y; logic [3:0] e;
        logic [31:0] pcs [6];
        pcs[0] = 32'h0000_0000; pcs[1] = 32'h0000_0008; pcs[2] = 32'h0000_0028;
        pcs[3] = 32'h0000_0078; pcs[4] = 32'h1234_5650; pcs[5] = 32'h0000_0060;
        for (int i = 0; i < 6; i++) begin
            do_lookup(pcs[i], h, t, y, e);
            chk(e === exp_en(pcs[i]), "R3", "bank enable", 64'(e), 64'(exp_en(pcs[i])));
        end
        @(negedge clk);
        chk(lk_bank_en === 4'd0 && lk_hit === 1'b0, "R2", "idle enable", 64'(lk_bank_en), 64'd0);
    endtask

    // R1 R5 R4: fill bank 0 with 16 entries, plus one in bank 1
    task automatic t_fill;
        for (int k = 0; k < 16; k++) do_update(mkpc(0, k, k), tgt_of(mkpc(0, k, k)), 2'(k));
        do_update(mkpc(1, 3, 2), tgt_of(mkpc(1, 3, 2)), 2'd3);
        for (int k = 0; k < 16; k++) expect_hit(mkpc(0, k, k), tgt_of(mkpc(0, k, k)), 2'(k), "R1");
        expect_hit(mkpc(1, 3, 2), tgt_of(mkpc(1, 3, 2)), 2'd3, "R5");
        // R4: output unchanged before the edge, valid just after
        @(negedge clk);
        lk_req = 1'b1; lk_pc = mkpc(0, 2, 2);
        #1;
        chk(lk_hit === 1'b0, "R4", "no hit before edge", 64'(lk_hit), 64'd0);
        @(posedge clk); #1;
        chk(lk_hit === 1'b1, "R4", "hit after one edge", 64'(lk_hit), 64'd1);
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    // R7 R6: low bits ignored; [4:3] selects bank; [6:5] is part of the tag
    task automatic t_tag_bits;
        logic [31:0] base;
        base = mkpc(0, 5, 1);
        expect_hit(base | 32'h5, tgt_of(base), 2'd1, "R7");
        expect_miss(base ^ 32'h08, "R7");
        expect_miss(base ^ 32'h28, "R7");
        expect_miss(mkpc(2, 40, 3), "R6");
    endtask

    // R9: repeated refresh of one PC in a full bank changes no other entry
    task automatic t_refresh;
        for (int n = 0; n < 5; n++) do_update(mkpc(0, 5, 5), 32'hCAFE_0000 + 32'(n), 2'd2);
        expect_hit(mkpc(0, 5, 5), 32'hCAFE_0004, 2'd2, "R9");
        for (int k = 0; k < 16; k++)
            if (k != 5) expect_hit(mkpc(0, k, k), tgt_of(mkpc(0, k, k)), 2'(k), "R9");
    endtask

    // R10 R8: rotating replacement starting from the first filled entry
    task automatic t_evict;
        do_update(mkpc(0, 16, 0), 32'h0000_1600, 2'd1);
        expect_miss(mkpc(0, 0, 0), "R10");
        expect_hit(mkpc(0, 16, 0), 32'h0000_1600, 2'd1, "R8");
        expect_hit(mkpc(0, 1, 1), tgt_of(mkpc(0, 1, 1)), 2'd1, "R10");
        do_update(mkpc(0, 17, 1), 32'h0000_1700, 2'd0);
        expect_miss(mkpc(0, 1, 1), "R10");
        expect_hit(mkpc(0, 2, 2), tgt_of(mkpc(0, 2, 2)), 2'd2, "R10");
        expect_hit(mkpc(1, 3, 2), tgt_of(mkpc(1, 3, 2)), 2'd3, "R10");
    endtask

    // R12: lookup alongside update sees old contents
    task automatic t_same_cycle;
        logic [31:0] pc;
        pc = mkpc(2, 7, 3);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_target = 32'hBEEF_0002; up_type = 2'd2;
        lk_req = 1'b1; lk_pc = pc;
        @(negedge clk);
        chk(lk_hit === 1'b0, "R12", "same-cycle miss", 64'(lk_hit), 64'd0);
        up_valid = 1'b0; lk_req = 1'b0;
        expect_hit(pc, 32'hBEEF_0002, 2'd2, "R12");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hash();
        t_fill();
        t_tag_bits();
        t_refresh();
        t_evict();
        t_same_cycle();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule